// File: doc/BRIEF.md
# SPI Memory Status and Write-Protect Controller

This block holds the command rules and the status register of a small serial memory. A serial front end hands it one decoded 8-bit opcode at a time, with the target byte address or the data byte that came with it. The block also watches an active-low write-protect pin and a busy flag from the internal write timer. From these it decides, for every array write and every status write, whether the request is granted or refused, and it signals when a granted request should start a write cycle.

The status byte it presents has a ready flag in bit 0, a write-enable latch in bit 1, a three-bit protect field in bits 4..2 and a pin-arm bit in bit 7. Bits 6..5 always read 0. The protect field locks a region at the top of the array, sized by parameters. The pin-arm bit decides whether the write-protect pin may lock the status register. The nonvolatile bits are modelled as flops that clear at reset.

Top module: `spi_stat_ctl`

## Requirements
- R1: A command with opcode 0x06 sets the write-enable latch (status bit 1) while busy is low.
- R2: A command with opcode 0x04 clears the latch while busy is low. No opcode other than 0x06 ever sets it. Opcodes 0x04 and 0x06 have no effect while busy is high.
- R3: An array write (opcode 0x02) or a status write (opcode 0x01) issued while the latch is 0 is refused: its block output pulses, its permit output stays low, and no cycle start is given.
- R4: While busy is high, status bit 0 reads 1 and every write or status write is refused. When busy is low, bit 0 reads 0.
- R5: A granted status write loads data bits 4..2 and 7 only. Bits 0, 1, 5 and 6 of the data byte have no effect on the status byte.
- R6: Protect field codes: 0 locks nothing, 1 locks the top page of 2^PAGE_W bytes, 2 locks the top quarter, and 3 to 7 lock the top half. An array write to a locked address is refused. An array write to any other address, with the latch set and busy low, is granted.
- R7: When status bit 7 is 1 and the write-protect pin is low, status writes are refused and the status byte is left unchanged. With the pin high, they are granted.
- R8: When status bit 7 is 0, the write-protect pin has no effect on status writes.
- R9: After a granted write or status write, the latch clears on the cycle after busy falls. A refused write does not clear it.
- R10: Every permit or block output is a one-cycle pulse, one cycle after the command. Permit and block are never high together. Cycle start pulses exactly with a permit.
- R11: After reset, all outputs are 0 and the status byte equals the busy input in bit 0, with all other bits 0. Unrecognised opcodes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | A decoded command is present this cycle |
| cmd_op_i | input | 8 | Opcode byte |
| cmd_addr_i | input | ADDR_W | Target byte address for array writes |
| cmd_data_i | input | 8 | Data byte for status writes |
| wp_n_i | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Internal write cycle is running |
| arr_permit_o | output | 1 | Array write granted (pulse) |
| arr_block_o | output | 1 | Array write refused (pulse) |
| sr_permit_o | output | 1 | Status write granted (pulse) |
| sr_block_o | output | 1 | Status write refused (pulse) |
| cycle_start_o | output | 1 | Start an internal write cycle (pulse) |
| status_o | output | 8 | Status byte |

## Verification
The assertions assume that a command lasts one cycle. They also assume that busy rises only after a cycle start, and that it falls before the next granted command. The bench keeps to these assumptions: it drives each command for exactly one cycle and raises busy for two cycles only after it sees a grant. It raises busy on its own only in the test where every write must be refused. The protect field is swept through all eight codes against all 128 addresses, with the pin kept high and bit 7 clear.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_WDIS = 8'h04;
  localparam logic [7:0] OP_SRWR = 8'h01;
  localparam logic [7:0] OP_AWR  = 8'h02;

  localparam int SB_RDY  = 0;
  localparam int SB_WEL  = 1;
  localparam int SB_BPLO = 2;
  localparam int SB_BPHI = 4;
  localparam int SB_ARM  = 7;

  typedef enum logic [2:0] {
    K_NONE, K_WEN, K_WDIS, K_SRWR, K_AWR, K_OTHER
  } cmd_kind_t;
endpackage

// File: rtl/spi_stat_decode.sv
module spi_stat_decode
  import spi_stat_pkg::*;
(
  input  logic       valid_i,
  input  logic [7:0] op_i,
  output cmd_kind_t  kind_o
);
  always_comb begin
    kind_o = K_NONE;
    if (valid_i) begin
      unique case (op_i)
        OP_WEN:  kind_o = K_WEN;
        OP_WDIS: kind_o = K_WDIS;
        OP_SRWR: kind_o = K_SRWR;
        OP_AWR:  kind_o = K_AWR;
        default: kind_o = K_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/spi_stat_protect.sv
module spi_stat_protect #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4
) (
  input  logic [2:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic top_page, top_quarter, top_half;

  always_comb begin
    top_page    = &addr_i[ADDR_W-1 -: HI_W];
    top_quarter = &addr_i[ADDR_W-1 -: 2];
    top_half    = addr_i[ADDR_W-1];
    unique case (bp_i)
      3'd0:    locked_o = 1'b0;
      3'd1:    locked_o = top_page;
      3'd2:    locked_o = top_quarter;
      default: locked_o = top_half;
    endcase
  end
endmodule

// File: rtl/spi_stat_regs.sv
module spi_stat_regs (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       busy_i,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       start_i,
  input  logic       load_i,
  input  logic [2:0] bp_d_i,
  input  logic       arm_d_i,
  output logic       wel_o,
  output logic [2:0] bp_o,
  output logic       arm_o
);
  logic       wel_q, wel_d;
  logic       pend_q, pend_d;
  logic       busy_q;
  logic [2:0] bp_q;
  logic       arm_q;
  logic       done;

  always_comb begin
    done   = pend_q & busy_q & ~busy_i;
    wel_d  = wel_q;
    pend_d = pend_q;
    if (done) begin
      wel_d  = 1'b0;
      pend_d = 1'b0;
    end
    if (clr_wel_i) wel_d  = 1'b0;
    if (set_wel_i) wel_d  = 1'b1;
    if (start_i)   pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wel_q  <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      wel_q  <= wel_d;
      pend_q <= pend_d;
      busy_q <= busy_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      bp_q  <= 3'd0;
      arm_q <= 1'b0;
    end else if (load_i) begin
      bp_q  <= bp_d_i;
      arm_q <= arm_d_i;
    end
  end

  assign wel_o = wel_q;
  assign bp_o  = bp_q;
  assign arm_o = arm_q;
endmodule

// File: rtl/spi_stat_ctl.sv
module spi_stat_ctl
  import spi_stat_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [7:0]        cmd_data_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  output logic              arr_permit_o,
  output logic              arr_block_o,
  output logic              sr_permit_o,
  output logic              sr_block_o,
  output logic              cycle_start_o,
  output logic [7:0]        status_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  cmd_kind_t  kind;
  logic       locked, wel, arm;
  logic [2:0] bp;
  logic       hw_lock, can_write;
  logic       arr_ok_d, arr_no_d, sr_ok_d, sr_no_d;
  logic       set_wel, clr_wel;

  spi_stat_decode i_dec (
    .valid_i (cmd_valid_i),
    .op_i    (cmd_op_i),
    .kind_o  (kind)
  );

  spi_stat_protect #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_prot (
    .bp_i     (bp),
    .addr_i   (cmd_addr_i),
    .locked_o (locked)
  );

  always_comb begin
    hw_lock   = arm & ~wp_n_i;
    can_write = wel & ~busy_i;
    arr_ok_d  = (kind == K_AWR)  & can_write & ~locked;
    arr_no_d  = (kind == K_AWR)  & ~arr_ok_d;
    sr_ok_d   = (kind == K_SRWR) & can_write & ~hw_lock;
    sr_no_d   = (kind == K_SRWR) & ~sr_ok_d;
    set_wel   = (kind == K_WEN)  & ~busy_i;
    clr_wel   = (kind == K_WDIS) & ~busy_i;
  end

  spi_stat_regs i_regs (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .busy_i    (busy_i),
    .set_wel_i (set_wel),
    .clr_wel_i (clr_wel),
    .start_i   (arr_ok_d | sr_ok_d),
    .load_i    (sr_ok_d),
    .bp_d_i    (cmd_data_i[SB_BPHI:SB_BPLO]),
    .arm_d_i   (cmd_data_i[SB_ARM]),
    .wel_o     (wel),
    .bp_o      (bp),
    .arm_o     (arm)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      arr_permit_o  <= 1'b0;
      arr_block_o   <= 1'b0;
      sr_permit_o   <= 1'b0;
      sr_block_o    <= 1'b0;
      cycle_start_o <= 1'b0;
    end else begin
      arr_permit_o  <= arr_ok_d;
      arr_block_o   <= arr_no_d;
      sr_permit_o   <= sr_ok_d;
      sr_block_o    <= sr_no_d;
      cycle_start_o <= arr_ok_d | sr_ok_d;
    end
  end

  always_comb begin
    status_o         = 8'h00;
    status_o[SB_RDY] = busy_i;
    status_o[SB_WEL] = wel;
    status_o[SB_BPHI:SB_BPLO] = bp;
    status_o[SB_ARM] = arm;
  end
endmodule

// File: rtl/spi_stat_ctl_chk.sv
module spi_stat_ctl_chk #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              cmd_valid_i,
  input logic [7:0]        cmd_op_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic [7:0]        cmd_data_i,
  input logic              wp_n_i,
  input logic              busy_i,
  input logic              arr_permit_o,
  input logic              arr_block_o,
  input logic              sr_permit_o,
  input logic              sr_block_o,
  input logic              cycle_start_o,
  input logic [7:0]        status_o
);
  a_r1_wen_sets: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cmd_valid_i && cmd_op_i == 8'h06 && !busy_i) |=> status_o[1]);

  a_r2_wel_only_by_wen: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(status_o[1]) |-> $past(cmd_valid_i && cmd_op_i == 8'h06));

  a_r4_no_grant_when_busy: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (arr_permit_o || sr_permit_o) |-> $past(!busy_i && status_o[1]));

  a_r7_pin_locks_sr: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sr_permit_o |-> $past(!(status_o[7] && !wp_n_i)));

  a_r5_sr_changes_only_on_grant: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable({status_o[7], status_o[4:2]}) |-> sr_permit_o);

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0({arr_permit_o, arr_block_o, sr_permit_o, sr_block_o}));

  a_r10_start_with_permit: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cycle_start_o == (arr_permit_o || sr_permit_o));

  a_r6_grant_needs_write: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    arr_permit_o |-> $past(cmd_valid_i && cmd_op_i == 8'h02));
endmodule

bind spi_stat_ctl spi_stat_ctl_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_chk (.*);

// File: tb/test_spi_stat_ctl.sv
`timescale 1ns/1ps
module test_spi_stat_ctl;
  localparam int AW = 7;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [7:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          wp_n;
  logic          busy;
  logic          arr_permit, arr_block, sr_permit, sr_block, cycle_start;
  logic [7:0]    status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_stat_ctl #(.ADDR_W(AW), .PAGE_W(PW)) i_spi_stat_ctl (
    .clk_i(clk), .rst_n_i(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .wp_n_i(wp_n), .busy_i(busy),
    .arr_permit_o(arr_permit), .arr_block_o(arr_block), .sr_permit_o(sr_permit),
    .sr_block_o(sr_block), .cycle_start_o(cycle_start), .status_o(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one command for one cycle; outputs are valid at the following negedge.
  task automatic send(input logic [7:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic complete();
    busy = 1'b1;
    repeat (2) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 8'h00; cmd_addr = '0;
    cmd_data = 8'h00; wp_n = 1'b1; busy = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset status", status, 8'h00);
    check("R11 reset outputs", {arr_permit, arr_block, sr_permit, sr_block, cycle_start}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: unrecognised opcode
    send(8'h05, '0, 8'hFF);
    check("R11 unknown op status", status, 8'h00);
    check("R11 unknown op outputs", {arr_permit, arr_block, sr_permit, sr_block}, 0);

    // R3: writes with latch clear
    send(8'h02, 7'd3, 8'h00);
    check("R3 write no latch", {arr_permit, arr_block, cycle_start}, 3'b010);
    send(8'h01, '0, 8'h0C);
    check("R3 srwr no latch", {sr_permit, sr_block, cycle_start}, 3'b010);
    check("R3 status kept", status, 8'h00);

    // R1 / R2
    send(8'h06, '0, 8'h00);
    check("R1 wen sets latch", status, 8'h02);
    check("R10 no pulse after wen", {arr_permit, arr_block, sr_permit, sr_block}, 0);
    send(8'h04, '0, 8'h00);
    check("R2 wdis clears latch", status, 8'h00);

    // R4: busy behaviour
    busy = 1'b1;
    @(negedge clk);
    check("R4 ready bit high", status, 8'h01);
    send(8'h06, '0, 8'h00);
    check("R2 wen ignored while busy", status, 8'h01);
    send(8'h02, 7'd0, 8'h00);
    check("R4 write refused busy", {arr_permit, arr_block, cycle_start}, 3'b010);
    busy = 1'b0;
    @(negedge clk);
    check("R4 ready bit low", status, 8'h00);
    send(8'h06, '0, 8'h00);
    busy = 1'b1;
    send(8'h01, '0, 8'h0C);
    check("R4 srwr refused busy", {sr_permit, sr_block, cycle_start}, 3'b010);
    check("R4 latch kept busy", status, 8'h03);
    send(8'h04, '0, 8'h00);
    check("R2 wdis ignored while busy", status, 8'h03);
    busy = 1'b0;
    @(negedge clk);
    send(8'h04, '0, 8'h00);

    // R5 / R9: status write masks, latch clears on completion
    send(8'h06, '0, 8'h00);
    send(8'h01, '0, 8'hFF);
    check("R10 srwr grant pulse", {sr_permit, sr_block, cycle_start}, 3'b101);
    check("R9 latch held until done", status, 8'h9E);
    @(negedge clk);
    check("R10 grant is a pulse", {sr_permit, cycle_start}, 2'b00);
    complete();
    check("R5 only bits 7,4..2 loaded", status, 8'h9C);
    check("R9 latch cleared after done", status[1], 1'b0);

    // R7: armed pin lock
    wp_n = 1'b0;
    send(8'h06, '0, 8'h00);
    send(8'h01, '0, 8'h00);
    check("R7 srwr locked by pin", {sr_permit, sr_block, cycle_start}, 3'b010);
    check("R7 status unchanged", status, 8'h9E);
    wp_n = 1'b1;
    send(8'h01, '0, 8'h00);
    check("R7 srwr granted pin high", {sr_permit, sr_block}, 2'b10);
    complete();
    check("R7 status cleared", status, 8'h00);

    // R8: unarmed pin ignored
    wp_n = 1'b0;
    send(8'h06, '0, 8'h00);
    send(8'h01, '0, 8'h08);
    check("R8 pin ignored when unarmed", {sr_permit, sr_block}, 2'b10);
    complete();
    check("R8 protect field loaded", status, 8'h08);
    wp_n = 1'b1;

    // R6: sweep every protect code against every address
    for (int bp = 0; bp < 8; bp++) begin
      send(8'h06, '0, 8'h00);
      send(8'h01, '0, 8'(bp << 2));
      complete();
      check("R6 protect code set", status, 8'(bp << 2));
      for (int a = 0; a < (1 << AW); a++) begin
        int  sz;
        bit  lk;
        sz = (bp == 0) ? 0 : (bp == 1) ? (1 << PW) : (bp == 2) ? (1 << (AW - 2)) : (1 << (AW - 1));
        lk = (a >= (1 << AW) - sz);
        send(8'h06, '0, 8'h00);
        send(8'h02, AW'(a), 8'h00);
        check($sformatf("R6 code %0d addr %0d", bp, a),
              {arr_permit, arr_block, cycle_start}, lk ? 3'b010 : 3'b101);
        if (!lk) begin
          complete();
          if (status[1] !== 1'b0) check("R9 latch after array write", status[1], 1'b0);
        end else begin
          send(8'h04, '0, 8'h00);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule